// File: doc/BRIEF.md
# Bidirectional Dual FIFO with Saved Pointers

This block holds two independent first-in first-out queues of 18-bit words, 1024 words each. One carries data from side A to side B, the other from side B to side A. Each side pushes and pops with single-cycle synchronous strobes. Each queue derives four status flags from its word count: empty, almost-empty, almost-full and full.

Two saved pointers let software replay or overwrite a block of data. The saved replay pointer belongs to the read side of the A-to-B queue. Software can capture the current read position into it and later restore the read pointer from it, so already-read words are delivered again. The saved overwrite pointer belongs to the write side of the B-to-A queue. Restoring from it rolls the write pointer back, so the words written since the capture are discarded and get written over.

Four flag pins each show one of the eight internal flags, chosen by a 3-bit code per pin. The almost thresholds are programmable.

Top module: `bififo_top`

## Requirements
- R1: A push when the queue is not full stores the word. A pop when the queue is not empty puts the oldest stored word on that queue's data output at the same clock edge. Words leave in the order they were pushed.
- R2: A queue's empty flag is 1 when its word count is 0. Its full flag is 1 when the count is 1024. The word count is the write pointer minus the read pointer, taken modulo 2048.
- R3: Almost-empty is 1 when count <= the empty threshold. Almost-full is 1 when count + the full threshold >= 1024. Both thresholds are 11 bits, are 8 after reset, and are loaded from cfg_ae_thr_i and cfg_af_thr_i on a clock edge with cfg_we_i high.
- R4: A push to a full queue leaves the count and the stored data unchanged. A pop from an empty queue leaves the count and the data output unchanged.
- R5: When reread_ni is low at an edge, the A-to-B read pointer takes the saved replay pointer, and any A-to-B pop in that cycle is ignored.
- R6: When load_reread_i is high at an edge, the saved replay pointer takes the A-to-B read pointer value from before that edge.
- R7: When rewrite_ni is low at an edge, the B-to-A write pointer takes the saved overwrite pointer, and any B-to-A push in that cycle is ignored.
- R8: When load_rewrite_i is high at an edge, the saved overwrite pointer takes the B-to-A write pointer value from before that edge.
- R9: Pin k of flag_o shows the flag whose code is in cfg_flag_sel_i[3k+2:3k], latched with cfg_we_i. The codes are: 0 A-to-B empty, 1 A-to-B almost-empty, 2 A-to-B almost-full, 3 A-to-B full, 4 B-to-A empty, 5 B-to-A almost-empty, 6 B-to-A almost-full, 7 B-to-A full.
- R10: While rst_ni is low, all pointers and both saved pointers are zero, the data outputs are zero, and the selection is pins 0..3 = codes 0, 3, 4, 7, so flag_o = 4'b0101.
- R11: The two queues work independently. Traffic, restores and captures on one queue never change the other queue's data or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ab_push_i | input | 1 | Push strobe, A-to-B queue |
| ab_data_i | input | 18 | Write data, A-to-B queue |
| ab_pop_i | input | 1 | Pop strobe, A-to-B queue |
| ab_data_o | output | 18 | Read data, A-to-B queue |
| ba_push_i | input | 1 | Push strobe, B-to-A queue |
| ba_data_i | input | 18 | Write data, B-to-A queue |
| ba_pop_i | input | 1 | Pop strobe, B-to-A queue |
| ba_data_o | output | 18 | Read data, B-to-A queue |
| reread_ni | input | 1 | Restore A-to-B read pointer from saved replay pointer, active low |
| load_reread_i | input | 1 | Capture A-to-B read pointer into saved replay pointer |
| rewrite_ni | input | 1 | Restore B-to-A write pointer from saved overwrite pointer, active low |
| load_rewrite_i | input | 1 | Capture B-to-A write pointer into saved overwrite pointer |
| cfg_we_i | input | 1 | Load flag selection and thresholds |
| cfg_flag_sel_i | input | 12 | Four 3-bit flag codes, pin 0 in the low bits |
| cfg_ae_thr_i | input | 11 | Almost-empty threshold |
| cfg_af_thr_i | input | 11 | Almost-full threshold |
| flag_o | output | 4 | Routed flag pins |

## Verification
Every result is due at the same clock edge that samples its cause. This covers a popped word on a data output, a pointer restore or capture, and a threshold or selection load. The flags follow from the updated pointers within that same cycle.

The bench drives strobes on the falling edge. It advances its own model once per cycle and compares the data outputs and flag_o 1 ns after the next rising edge. A result therefore never lands a cycle early or late without being reported.

Directed sequences cover the threshold crossings, a full fill with an overflow push, a drain ending in an underflow pop, a replay, and an overwrite. A fixed-seed random phase then mixes strobes, restores, captures and reconfiguration.

// File: rtl/bififo_pkg.sv
package bififo_pkg;
  localparam int unsigned FLAGS_PER_DIR = 4;
  localparam int unsigned N_PINS        = 4;
  localparam int unsigned SEL_W         = 3;

  // bit index inside a direction's flag vector
  localparam int unsigned FL_EMPTY  = 0;
  localparam int unsigned FL_AEMPTY = 1;
  localparam int unsigned FL_AFULL  = 2;
  localparam int unsigned FL_FULL   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_AB_EMPTY  = 3'd0,
    SEL_AB_AEMPTY = 3'd1,
    SEL_AB_AFULL  = 3'd2,
    SEL_AB_FULL   = 3'd3,
    SEL_BA_EMPTY  = 3'd4,
    SEL_BA_AEMPTY = 3'd5,
    SEL_BA_AFULL  = 3'd6,
    SEL_BA_FULL   = 3'd7
  } flag_code_e;

  localparam logic [N_PINS*SEL_W-1:0] SEL_RESET =
    {SEL_BA_FULL, SEL_BA_EMPTY, SEL_AB_FULL, SEL_AB_EMPTY};
endpackage

// File: rtl/bififo_mem.sv
module bififo_mem #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/bififo_flag_calc.sv
module bififo_flag_calc
  import bififo_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic [AW:0]              cnt_i,
  input  logic [AW:0]              ae_thr_i,
  input  logic [AW:0]              af_thr_i,
  output logic [FLAGS_PER_DIR-1:0] flags_o
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW:0] af_sum;

  assign af_sum = {1'b0, cnt_i} + {1'b0, af_thr_i};

  always_comb begin
    flags_o            = '0;
    flags_o[FL_EMPTY]  = (cnt_i == '0);
    flags_o[FL_AEMPTY] = (cnt_i <= ae_thr_i);
    flags_o[FL_AFULL]  = (af_sum >= (PW+1)'(DEPTH));
    flags_o[FL_FULL]   = (cnt_i == PW'(DEPTH));
  end
endmodule

// File: rtl/bififo_dir.sv
module bififo_dir
  import bififo_pkg::*;
#(
  parameter int unsigned DW          = 18,
  parameter int unsigned AW          = 10,
  parameter bit          SHADOW_ON_RD = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     pop_i,
  output logic [DW-1:0]            rdata_o,
  input  logic                     restore_i,
  input  logic                     save_i,
  input  logic [AW:0]              ae_thr_i,
  input  logic [AW:0]              af_thr_i,
  output logic [FLAGS_PER_DIR-1:0] flags_o,
  output logic [AW:0]              cnt_o,
  output logic [AW:0]              rptr_o,
  output logic [AW:0]              wptr_o,
  output logic [AW:0]              shadow_o
);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] rptr_q, wptr_q, shadow_q;
  logic [PW-1:0] rptr_d, wptr_d, shadow_d;
  logic          rd_go, wr_go;
  logic          empty, full;

  assign cnt_o = wptr_q - rptr_q;
  assign empty = flags_o[FL_EMPTY];
  assign full  = flags_o[FL_FULL];

  generate
    if (SHADOW_ON_RD) begin : g_rd_shadow
      // restore wins over a pop in the same cycle
      assign rd_go    = pop_i & ~empty & ~restore_i;
      assign wr_go    = push_i & ~full;
      assign rptr_d   = restore_i ? shadow_q : rptr_q + PW'(rd_go);
      assign wptr_d   = wptr_q + PW'(wr_go);
      assign shadow_d = save_i ? rptr_q : shadow_q;
    end else begin : g_wr_shadow
      // restore wins over a push in the same cycle
      assign rd_go    = pop_i & ~empty;
      assign wr_go    = push_i & ~full & ~restore_i;
      assign rptr_d   = rptr_q + PW'(rd_go);
      assign wptr_d   = restore_i ? shadow_q : wptr_q + PW'(wr_go);
      assign shadow_d = save_i ? wptr_q : shadow_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q   <= '0;
      wptr_q   <= '0;
      shadow_q <= '0;
    end else begin
      rptr_q   <= rptr_d;
      wptr_q   <= wptr_d;
      shadow_q <= shadow_d;
    end
  end

  assign rptr_o   = rptr_q;
  assign wptr_o   = wptr_q;
  assign shadow_o = shadow_q;

  bififo_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_go),
    .waddr_i (wptr_q[AW-1:0]),
    .wdata_i (wdata_i),
    .re_i    (rd_go),
    .raddr_i (rptr_q[AW-1:0]),
    .rdata_o (rdata_o)
  );

  bififo_flag_calc #(.AW(AW)) u_flags (
    .cnt_i    (cnt_o),
    .ae_thr_i (ae_thr_i),
    .af_thr_i (af_thr_i),
    .flags_o  (flags_o)
  );
endmodule

// File: rtl/bififo_cfg.sv
module bififo_cfg
  import bififo_pkg::*;
#(
  parameter int unsigned CW      = 11,
  parameter int unsigned DEF_THR = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [N_PINS*SEL_W-1:0]    sel_i,
  input  logic [CW-1:0]              ae_i,
  input  logic [CW-1:0]              af_i,
  input  logic [2*FLAGS_PER_DIR-1:0] all_flags_i,
  output logic [CW-1:0]              ae_o,
  output logic [CW-1:0]              af_o,
  output logic [N_PINS-1:0]          flag_o
);
  logic [N_PINS*SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_RESET;
      ae_o  <= CW'(DEF_THR);
      af_o  <= CW'(DEF_THR);
    end else if (we_i) begin
      sel_q <= sel_i;
      ae_o  <= ae_i;
      af_o  <= af_i;
    end
  end

  generate
    for (genvar k = 0; k < N_PINS; k++) begin : g_pin
      assign flag_o[k] = all_flags_i[sel_q[k*SEL_W +: SEL_W]];
    end
  endgenerate
endmodule

// File: rtl/bififo_top.sv
module bififo_top
  import bififo_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ab_push_i,
  input  logic [DW-1:0]           ab_data_i,
  input  logic                    ab_pop_i,
  output logic [DW-1:0]           ab_data_o,
  input  logic                    ba_push_i,
  input  logic [DW-1:0]           ba_data_i,
  input  logic                    ba_pop_i,
  output logic [DW-1:0]           ba_data_o,
  input  logic                    reread_ni,
  input  logic                    load_reread_i,
  input  logic                    rewrite_ni,
  input  logic                    load_rewrite_i,
  input  logic                    cfg_we_i,
  input  logic [N_PINS*SEL_W-1:0] cfg_flag_sel_i,
  input  logic [AW:0]             cfg_ae_thr_i,
  input  logic [AW:0]             cfg_af_thr_i,
  output logic [N_PINS-1:0]       flag_o
);
  localparam int unsigned CW = AW + 1;

  logic [CW-1:0]              ae_thr, af_thr;
  logic [FLAGS_PER_DIR-1:0]   ab_flags, ba_flags;
  logic [CW-1:0]              ab_cnt, ab_rptr, ab_wptr, ab_shadow;
  logic [CW-1:0]              ba_cnt, ba_rptr, ba_wptr, ba_shadow;

  bififo_dir #(.DW(DW), .AW(AW), .SHADOW_ON_RD(1'b1)) u_ab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (ab_push_i),
    .wdata_i   (ab_data_i),
    .pop_i     (ab_pop_i),
    .rdata_o   (ab_data_o),
    .restore_i (~reread_ni),
    .save_i    (load_reread_i),
    .ae_thr_i  (ae_thr),
    .af_thr_i  (af_thr),
    .flags_o   (ab_flags),
    .cnt_o     (ab_cnt),
    .rptr_o    (ab_rptr),
    .wptr_o    (ab_wptr),
    .shadow_o  (ab_shadow)
  );

  bififo_dir #(.DW(DW), .AW(AW), .SHADOW_ON_RD(1'b0)) u_ba (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (ba_push_i),
    .wdata_i   (ba_data_i),
    .pop_i     (ba_pop_i),
    .rdata_o   (ba_data_o),
    .restore_i (~rewrite_ni),
    .save_i    (load_rewrite_i),
    .ae_thr_i  (ae_thr),
    .af_thr_i  (af_thr),
    .flags_o   (ba_flags),
    .cnt_o     (ba_cnt),
    .rptr_o    (ba_rptr),
    .wptr_o    (ba_wptr),
    .shadow_o  (ba_shadow)
  );

  bififo_cfg #(.CW(CW), .DEF_THR(8)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .sel_i       (cfg_flag_sel_i),
    .ae_i        (cfg_ae_thr_i),
    .af_i        (cfg_af_thr_i),
    .all_flags_i ({ba_flags, ab_flags}),
    .ae_o        (ae_thr),
    .af_o        (af_thr),
    .flag_o      (flag_o)
  );
endmodule

// File: rtl/bififo_chk.sv
module bififo_chk #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ab_push_i,
  input logic          ab_pop_i,
  input logic          ba_push_i,
  input logic          ba_pop_i,
  input logic          reread_ni,
  input logic          load_reread_i,
  input logic          rewrite_ni,
  input logic          load_rewrite_i,
  input logic [3:0]    ab_flags_i,
  input logic [3:0]    ba_flags_i,
  input logic [AW:0]   ab_cnt_i,
  input logic [AW:0]   ab_rptr_i,
  input logic [AW:0]   ab_shadow_i,
  input logic [AW:0]   ba_cnt_i,
  input logic [AW:0]   ba_wptr_i,
  input logic [AW:0]   ba_shadow_i,
  input logic [DW-1:0] ab_data_i,
  input logic [DW-1:0] ba_data_i
);
  localparam int unsigned PW = AW + 1;

  logic ab_empty, ab_full, ba_empty, ba_full;
  assign ab_empty = ab_flags_i[0];
  assign ab_full  = ab_flags_i[3];
  assign ba_empty = ba_flags_i[0];
  assign ba_full  = ba_flags_i[3];

  assert_push_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_push_i && !ab_full && !ab_pop_i && reread_ni |=> ab_cnt_i == PW'($past(ab_cnt_i) + 1'b1));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_push_i && ab_full && !ab_pop_i && reread_ni |=> $stable(ab_cnt_i));

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_pop_i && ab_empty && reread_ni |=> $stable(ab_data_i));

  assert_ba_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_pop_i && ba_empty |=> $stable(ba_data_i));

  assert_ba_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_push_i && ba_full && !ba_pop_i && rewrite_ni |=> $stable(ba_cnt_i));

  assert_reread_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reread_ni |=> ab_rptr_i == $past(ab_shadow_i));

  assert_load_reread_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_reread_i |=> ab_shadow_i == $past(ab_rptr_i));

  assert_rewrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rewrite_ni |=> ba_wptr_i == $past(ba_shadow_i));

  assert_load_rewrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_rewrite_i |=> ba_shadow_i == $past(ba_wptr_i));

  // R11: idle B-to-A queue is untouched by A-to-B traffic
  assert_ba_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ba_push_i && !ba_pop_i && rewrite_ni |=> $stable(ba_cnt_i) && $stable(ba_data_i));
endmodule

bind bififo_top bififo_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ab_push_i      (ab_push_i),
  .ab_pop_i       (ab_pop_i),
  .ba_push_i      (ba_push_i),
  .ba_pop_i       (ba_pop_i),
  .reread_ni      (reread_ni),
  .load_reread_i  (load_reread_i),
  .rewrite_ni     (rewrite_ni),
  .load_rewrite_i (load_rewrite_i),
  .ab_flags_i     (ab_flags),
  .ba_flags_i     (ba_flags),
  .ab_cnt_i       (ab_cnt),
  .ab_rptr_i      (ab_rptr),
  .ab_shadow_i    (ab_shadow),
  .ba_cnt_i       (ba_cnt),
  .ba_wptr_i      (ba_wptr),
  .ba_shadow_i    (ba_shadow),
  .ab_data_i      (ab_data_o),
  .ba_data_i      (ba_data_o)
);

// File: tb/tb_bififo_top.sv
`timescale 1ns/1ps
module tb_bififo_top;
  localparam int DW = 18;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          ab_push, ab_pop, ba_push, ba_pop;
  logic [DW-1:0] ab_din, ba_din;
  wire  [DW-1:0] ab_dout, ba_dout;
  logic          reread_n, ld_rr, rewrite_n, ld_rw, cfg_we;
  logic [11:0]   cfg_sel;
  logic [AW:0]   cfg_ae, cfg_af;
  wire  [3:0]    flag;

  bififo_top #(.DW(DW), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ab_push_i(ab_push), .ab_data_i(ab_din), .ab_pop_i(ab_pop), .ab_data_o(ab_dout),
    .ba_push_i(ba_push), .ba_data_i(ba_din), .ba_pop_i(ba_pop), .ba_data_o(ba_dout),
    .reread_ni(reread_n), .load_reread_i(ld_rr),
    .rewrite_ni(rewrite_n), .load_rewrite_i(ld_rw),
    .cfg_we_i(cfg_we), .cfg_flag_sel_i(cfg_sel),
    .cfg_ae_thr_i(cfg_ae), .cfg_af_thr_i(cfg_af),
    .flag_o(flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model
  logic [DW-1:0] mab [DEPTH];
  logic [DW-1:0] mba [DEPTH];
  logic [AW:0]   ab_w, ab_r, ab_s, ba_w, ba_r, ba_s;
  logic [DW-1:0] e_ab, e_ba;
  logic [11:0]   m_sel;
  logic [AW:0]   m_ae, m_af;

  function automatic logic [3:0] dir_flags(logic [AW:0] c, logic [AW:0] ae, logic [AW:0] af);
    logic [AW+1:0] s;
    s = {1'b0, c} + {1'b0, af};
    return {c == AW'(0) + (AW+1)'(DEPTH), s >= (AW+2)'(DEPTH), c <= ae, c == '0};
  endfunction

  function automatic logic [3:0] exp_flags();
    logic [7:0] all;
    logic [3:0] r;
    all = {dir_flags(ba_w - ba_r, m_ae, m_af), dir_flags(ab_w - ab_r, m_ae, m_af)};
    for (int k = 0; k < 4; k++) r[k] = all[m_sel[k*3 +: 3]];
    return r;
  endfunction

  task automatic model_reset();
    ab_w = '0; ab_r = '0; ab_s = '0; ba_w = '0; ba_r = '0; ba_s = '0;
    e_ab = '0; e_ba = '0; m_sel = 12'hF18; m_ae = 11'd8; m_af = 11'd8;
  endtask

  task automatic model_step();
    logic [AW:0] c;
    logic rd, wr;
    logic [AW:0] old;
    c  = ab_w - ab_r;
    rd = ab_pop && c != 0 && reread_n;
    wr = ab_push && c != (AW+1)'(DEPTH);
    if (rd) e_ab = mab[ab_r[AW-1:0]];
    if (wr) mab[ab_w[AW-1:0]] = ab_din;
    old = ab_r;
    if (!reread_n) ab_r = ab_s; else ab_r = ab_r + (AW+1)'(rd);
    if (ld_rr) ab_s = old;
    ab_w = ab_w + (AW+1)'(wr);
    c  = ba_w - ba_r;
    rd = ba_pop && c != 0;
    wr = ba_push && c != (AW+1)'(DEPTH) && rewrite_n;
    if (rd) e_ba = mba[ba_r[AW-1:0]];
    if (wr) mba[ba_w[AW-1:0]] = ba_din;
    old = ba_w;
    if (!rewrite_n) ba_w = ba_s; else ba_w = ba_w + (AW+1)'(wr);
    if (ld_rw) ba_s = old;
    ba_r = ba_r + (AW+1)'(rd);
    if (cfg_we) begin m_sel = cfg_sel; m_ae = cfg_ae; m_af = cfg_af; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    ab_push = 0; ab_pop = 0; ba_push = 0; ba_pop = 0;
    reread_n = 1; ld_rr = 0; rewrite_n = 1; ld_rw = 0; cfg_we = 0;
  endtask

  // inputs already applied at a falling edge
  task automatic cycle(string freq);
    model_step();
    @(posedge clk); #1;
    chk("R1 ab data", ab_dout, e_ab);
    chk("R11 ba data", ba_dout, e_ba);
    chk(freq, flag, exp_flags());
    @(negedge clk);
    idle();
  endtask

  task automatic set_cfg(logic [11:0] s, logic [AW:0] ae, logic [AW:0] af);
    cfg_we = 1; cfg_sel = s; cfg_ae = ae; cfg_af = af;
    cycle("R9 cfg");
  endtask

  task automatic ab_wr(logic [DW-1:0] d); ab_push = 1; ab_din = d; cycle("R2 ab push"); endtask
  task automatic ab_rd();                 ab_pop = 1;               cycle("R2 ab pop");  endtask
  task automatic ba_wr(logic [DW-1:0] d); ba_push = 1; ba_din = d; cycle("R2 ba push"); endtask
  task automatic ba_rd();                 ba_pop = 1;               cycle("R2 ba pop");  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] hold;
    int unsigned seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    idle(); ab_din = '0; ba_din = '0; cfg_sel = '0; cfg_ae = '0; cfg_af = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 flags in reset", flag, 4'b0101);
    chk("R10 ab data in reset", ab_dout, 0);
    chk("R10 ba data in reset", ba_dout, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 default almost-empty threshold 8, pin0 = code 1, pin1 = code 2
    set_cfg(12'hD51, 11'd8, 11'd8);
    for (int i = 0; i < 8; i++) ab_wr(DW'(i));
    chk("R3 aempty at count 8", flag[0], 1'b1);
    ab_wr(DW'(8));
    chk("R3 aempty clears at count 9", flag[0], 1'b0);
    for (int i = 9; i < 1015; i++) ab_wr(DW'(i));
    chk("R3 afull clear at 1015", flag[1], 1'b0);
    ab_wr(DW'(1015));
    chk("R3 afull set at 1016", flag[1], 1'b1);
    for (int i = 1016; i < DEPTH; i++) ab_wr(DW'(i));
    set_cfg(12'hF18, 11'd8, 11'd8);
    chk("R2 full at 1024", flag[1], 1'b1);
    ab_wr(18'h3FFFF);
    chk("R4 push on full keeps full", flag[1], 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      ab_rd();
      if (i == 0 || i == DEPTH-1) chk("R1 order", ab_dout, DW'(i));
    end
    chk("R2 empty after drain", flag[0], 1'b1);
    hold = ab_dout;
    ab_rd();
    chk("R4 pop on empty keeps data", ab_dout, hold);
    chk("R4 pop on empty keeps empty", flag[0], 1'b1);

    // R3 programmed threshold
    set_cfg(12'hD51, 11'd3, 11'd8);
    for (int i = 0; i < 3; i++) ab_wr(DW'(i));
    chk("R3 aempty with thr 3", flag[0], 1'b1);
    ab_wr(DW'(3));
    chk("R3 aempty clear with thr 3", flag[0], 1'b0);
    for (int i = 0; i < 4; i++) ab_rd();
    set_cfg(12'hF18, 11'd8, 11'd8);

    // R5/R6 replay
    ld_rr = 1; cycle("R6 capture");
    for (int i = 0; i < 5; i++) ab_wr(DW'(18'h1000 + i));
    for (int i = 0; i < 5; i++) ab_rd();
    chk("R5 empty before replay", flag[0], 1'b1);
    reread_n = 0; ab_pop = 1; cycle("R5 restore");
    chk("R5 pop during restore ignored", ab_dout, 18'h1004);
    ab_rd(); chk("R5 replay word0", ab_dout, 18'h1000);
    ab_rd(); chk("R5 replay word1", ab_dout, 18'h1001);
    ld_rr = 1; cycle("R6 capture mid");
    ab_rd(); ab_rd();
    reread_n = 0; cycle("R6 restore mid");
    ab_rd(); chk("R6 replay from captured point", ab_dout, 18'h1002);
    for (int i = 0; i < 2; i++) ab_rd();

    // R7/R8 overwrite
    ba_wr(18'h2000);
    ba_rd();
    ld_rw = 1; cycle("R8 capture");
    ba_wr(18'h2A); ba_wr(18'h2B); ba_wr(18'h2C);
    rewrite_n = 0; ba_push = 1; ba_din = 18'h3FFFF; cycle("R7 restore");
    chk("R7 ba empty after rollback", flag[2], 1'b1);
    ba_wr(18'h3A); ba_wr(18'h3B);
    ba_rd(); chk("R7 overwritten word0", ba_dout, 18'h3A);
    ba_rd(); chk("R7 overwritten word1", ba_dout, 18'h3B);
    chk("R8 ba empty after two pops", flag[2], 1'b1);
    chk("R11 ab untouched by ba traffic", flag[0], 1'b1);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      ab_push   = ($urandom % 100) < 55;
      ab_pop    = ($urandom % 100) < 50;
      ba_push   = ($urandom % 100) < 50;
      ba_pop    = ($urandom % 100) < 55;
      ab_din    = DW'($urandom);
      ba_din    = DW'($urandom);
      reread_n  = ($urandom % 64) != 0;
      ld_rr     = ($urandom % 32) == 0;
      rewrite_n = ($urandom % 64) != 0;
      ld_rw     = ($urandom % 32) == 0;
      cfg_we    = ($urandom % 200) == 0;
      cfg_sel   = 12'($urandom);
      cfg_ae    = 11'($urandom % 40);
      cfg_af    = 11'($urandom % 40);
      cycle("R9 random flags");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule